// File: doc/BRIEF.md
# Integer ALU Flag Update Unit

This block is the back end of a 32-bit integer execution stage. Each cycle it may take two operands, an operation and three per-instruction enables. It produces a registered result word and the updated architectural status. The status has two parts: a three-bit exception word (sticky summary-overflow, overflow, carry) and a 32-bit condition register that holds eight four-bit fields.

Addition is formed at double width. The operands are zero-extended to derive the carry-out and sign-extended to derive signed overflow. The add-with-carry operation takes the current carry flag as its carry-in. Bitwise operations cannot produce a carry or an overflow. When the record enable is set, condition field 0 is rewritten with a compare of the result against zero, and the sticky summary-overflow bit is copied into that field. The other seven fields are left as they were.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the result, the exception word and the condition register to zero.
- R2: Outputs are registered. An operation presented with `in_valid` high appears on the outputs after the next rising edge. When `in_valid` is low, all outputs hold their values.
- R3: Opcode encodings are 0 add, 1 add-with-carry, 2 and, 3 or, 4 xor, 5 not (of operand A). For add the result is A+B modulo 2^32. For add-with-carry the result is A+B plus the current carry flag.
- R4: When `upd_carry` is set, the carry flag (`xer_out[0]`) becomes the carry out of bit 31 of the unsigned sum. Bitwise operations give a carry of 0. When `upd_carry` is clear, the carry flag is unchanged.
- R5: When `ovf_en` is set and a signed overflow occurs, the overflow flag (`xer_out[1]`) and the summary-overflow flag (`xer_out[2]`) are both set. Bitwise operations never overflow.
- R6: When `ovf_en` is set and there is no overflow, the overflow flag is cleared and summary-overflow keeps its value (sticky). When `ovf_en` is clear, both flags are unchanged.
- R7: When `record` is set, condition bits [31:28] are written as {LT, GT, EQ, SO}. Exactly one of LT, GT and EQ is set, from a signed compare of the result with zero. SO is the summary-overflow value after this operation.
- R8: Recording writes only bits [31:28]. Bits [27:0] of the condition register are never changed, and bits [31:28] are unchanged when `record` is clear.
- R9: Opcodes 6 and 7 produce a result of zero and are otherwise treated as bitwise operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| upd_carry | input | 1 | Update carry flag |
| ovf_en | input | 1 | Update overflow and summary-overflow flags |
| record | input | 1 | Write condition field 0 |
| result | output | 32 | Registered result |
| xer_out | output | 3 | {summary-overflow, overflow, carry} |
| cr_out | output | 32 | Condition register |

## Verification
The hardest state to reach is a cleared overflow flag next to a summary-overflow flag that is still set. Only a sequence produces it: an overflowing add with `ovf_en` set, then a non-overflowing add with `ovf_en` set. A later recorded zero result must then show both EQ and SO in field 0. The condition register's low 28 bits are always zero from the ports, so the bench checks that they stay zero while only the top nibble changes. The carry-in path is checked by chaining 0xFFFFFFFF+1 (which sets the carry) into an add-with-carry.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    localparam int WORD_W  = 32;
    localparam int WIDE_W  = 2 * WORD_W;
    localparam int FIELD_W = 4;
    localparam int NFIELDS = WORD_W / FIELD_W;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOT  = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xer_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
        logic              ovf;
    } alu_res_t;

    function automatic logic [FIELD_W-1:0] cmp_zero(input logic [WORD_W-1:0] v, input logic so);
        logic neg, zer;
        neg = v[WORD_W-1];
        zer = (v == '0);
        return {neg, !neg && !zer, zer, so};
    endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    output alu_res_t          res
);
    logic [WIDE_W-1:0] uz_sum, sx_sum;
    logic [WIDE_W-1:0] cin_w;
    logic [WORD_W-1:0] logic_v;
    logic              is_add;

    always_comb begin
        is_add = (op == OP_ADD) || (op == OP_ADDC);
        cin_w  = {{(WIDE_W-1){1'b0}}, (op == OP_ADDC) ? cin : 1'b0};
        uz_sum = {{WORD_W{1'b0}}, a} + {{WORD_W{1'b0}}, b} + cin_w;
        sx_sum = {{WORD_W{a[WORD_W-1]}}, a} + {{WORD_W{b[WORD_W-1]}}, b} + cin_w;
        case (op)
            OP_AND:  logic_v = a & b;
            OP_OR:   logic_v = a | b;
            OP_XOR:  logic_v = a ^ b;
            OP_NOT:  logic_v = ~a;
            default: logic_v = '0;
        endcase
        if (is_add) begin
            res.value = uz_sum[WORD_W-1:0];
            res.carry = uz_sum[WORD_W];
            res.ovf   = sx_sum[WORD_W] != sx_sum[WORD_W-1];
        end else begin
            res.value = logic_v;
            res.carry = 1'b0;
            res.ovf   = 1'b0;
        end
    end
endmodule

// File: rtl/flag_update.sv
module flag_update
    import alu_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  alu_res_t          res,
    input  logic              upd_carry,
    input  logic              ovf_en,
    input  logic              record,
    output xer_t              xer_q,
    output logic [WORD_W-1:0] cr_q
);
    xer_t              xer_d;
    logic [WORD_W-1:0] cr_d;

    always_comb begin
        xer_d = xer_q;
        if (upd_carry) xer_d.ca = res.carry;
        if (ovf_en) begin
            xer_d.ov = res.ovf;
            if (res.ovf) xer_d.so = 1'b1;
        end
        cr_d = cr_q;
        for (int f = 0; f < NFIELDS; f++) begin
            if (record && f == 0)
                cr_d[WORD_W-1-FIELD_W*f -: FIELD_W] = cmp_zero(res.value, xer_d.so);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xer_q <= '0;
            cr_q  <= '0;
        end else if (en) begin
            xer_q <= xer_d;
            cr_q  <= cr_d;
        end
    end

    assert_so_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        $past(xer_q.so) && !$past(rst) |-> xer_q.so);
    assert_low_fields_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cr_q[WORD_W-FIELD_W-1:0] == $past(cr_q[WORD_W-FIELD_W-1:0]));
    assert_field0_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(en && record) |-> $countones(cr_q[WORD_W-1:WORD_W-3]) == 1);
    assert_ov_sets_so_R5: assert property (@(posedge clk) disable iff (rst)
        xer_q.ov |-> xer_q.so);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  op,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        upd_carry,
    input  logic        ovf_en,
    input  logic        record,
    output logic [31:0] result,
    output logic [2:0]  xer_out,
    output logic [31:0] cr_out
);
    alu_res_t          res;
    xer_t              xer_q;
    logic [WORD_W-1:0] res_q;

    alu_core u_core (.op(op), .a(opnd_a), .b(opnd_b), .cin(xer_q.ca), .res(res));

    flag_update u_flags (
        .clk(clk), .rst(rst), .en(in_valid), .res(res),
        .upd_carry(upd_carry), .ovf_en(ovf_en), .record(record),
        .xer_q(xer_q), .cr_q(cr_out)
    );

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= res.value;
    end

    assign result  = res_q;
    assign xer_out = xer_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(in_valid) |-> $stable(result) && $stable(xer_out));
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> result == '0);
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
    logic        clk = 0, rst = 1, in_valid = 0, upd_carry = 0, ovf_en = 0, record = 0;
    logic [2:0]  op = 0;
    logic [31:0] opnd_a = 0, opnd_b = 0;
    logic [31:0] result, cr_out;
    logic [2:0]  xer_out;
    int checks = 0, errors = 0;

    alu_flag_unit u_dut (.*);

    always #2 clk = ~clk;

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic ca, input logic ov, input logic rc);
        op = o; opnd_a = a; opnd_b = b; upd_carry = ca; ovf_en = ov; record = rc; in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 result", result, 0);
        chk("R1 xer", {29'd0, xer_out}, 0);
        chk("R1 cr", cr_out, 0);
    endtask

    task automatic t_overflow_seq();
        issue(0, 32'h7FFFFFFF, 1, 1, 1, 1);
        chk("R3 add", result, 32'h80000000);
        chk("R5 ov+so", {29'd0, xer_out}, 3'b110);
        chk("R7 cr neg+so", cr_out, 32'h9000_0000);
        issue(0, 5, 6, 0, 1, 0);
        chk("R6 ov clr so kept", {29'd0, xer_out}, 3'b100);
        chk("R8 cr unchanged", cr_out, 32'h9000_0000);
        issue(2, 32'hF0, 32'h0F, 0, 0, 1);
        chk("R7 zero+so", cr_out, 32'h3000_0000);
    endtask

    task automatic t_carry();
        issue(0, 32'hFFFFFFFF, 1, 1, 0, 1);
        chk("R3 wrap", result, 0);
        chk("R4 carry set", {31'd0, xer_out[0]}, 1);
        issue(1, 10, 20, 0, 0, 1);
        chk("R3 addc", result, 31);
        chk("R4 carry kept", {31'd0, xer_out[0]}, 1);
        chk("R7 pos", cr_out, 32'h5000_0000);
        issue(3, 32'hFFFFFFFF, 0, 1, 1, 0);
        chk("R4 bitwise carry 0", {29'd0, xer_out}, 3'b100);
    endtask

    task automatic t_logic();
        issue(4, 32'hFF00FF00, 32'h0FF00FF0, 0, 0, 0);
        chk("R3 xor", result, 32'hF0F0F0F0);
        issue(5, 32'h12345678, 0, 0, 0, 0);
        chk("R3 not", result, 32'hEDCBA987);
        issue(6, 32'h1234, 32'h5678, 0, 0, 0);
        chk("R9 op6", result, 0);
        op = 0; opnd_a = 1; opnd_b = 1; @(posedge clk); #1;
        chk("R2 hold", result, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_overflow_seq();
        t_carry();
        t_logic();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule